// File: doc/BRIEF.md
# Word-Divisor Integer Divide Unit

This unit divides a 32-bit dividend by a 16-bit divisor over several clock cycles. One operation starts with a single-cycle strobe. A per-operation select chooses signed (two's complement) or unsigned arithmetic. The unit produces a 16-bit quotient and a 16-bit remainder and packs them into one 32-bit word: the remainder goes in the upper half and the quotient in the lower half. It also updates four condition flags: negative, zero, overflow and carry.

Signed operands are first reduced to their magnitudes. One restoring step then runs per clock, and each step yields one quotient bit. After the last step the signs are put back and the result is checked against the 16-bit quotient range. If the quotient does not fit, the unit returns the original dividend, sets the overflow flag and keeps the previous negative and zero flags. A zero divisor starts no iteration. It produces a one-cycle exception pulse and leaves the result and flags as they were.

Top module: `word_div_unit`

## Requirements
- R1: In unsigned mode (`signed_i`=0) with a quotient of at most 65535, `result_o` equals {remainder[15:0], quotient[15:0]}, with the remainder in bits 31:16 and the quotient in bits 15:0.
- R2: In signed mode (`signed_i`=1), the quotient is truncated toward zero and a nonzero remainder takes the sign of the dividend, both packed as in R1.
- R3: In unsigned mode, a quotient above 65535 makes `result_o` equal the original dividend and sets `v_o`=1 and `c_o`=0, while `n_o` and `z_o` keep their previous values.
- R4: In signed mode, a true quotient outside -32768..32767 gives the same outcome as R3.
- R5: When the result is normal, `n_o` equals quotient bit 15, `z_o` is 1 exactly when the 16-bit quotient is zero, and `v_o`=`c_o`=0.
- R6: A start with a divisor of zero makes `div_zero_o` high for exactly the one cycle after the start edge. `busy_o` and `done_o` stay low, and `result_o` and the flags keep their values.
- R7: After an accepted start edge, `busy_o` is high for 16 cycles. On the 16th edge `busy_o` falls and `done_o` is high for one cycle. `result_o` and the flags then hold until the next completed operation.
- R8: A `start_i` that arrives while `busy_o` is high is ignored, so the running operation completes with its own operands.
- R9: After reset, `busy_o`, `done_o`, `div_zero_o`, `result_o` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when the unit is idle |
| signed_i | input | 1 | 1 selects signed division, 0 unsigned |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 16 | Divisor |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | {remainder, quotient}, or the dividend on overflow |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag, cleared by every completion |
| div_zero_o | output | 1 | One-cycle divide-by-zero pulse |

## Verification
The bench builds the unit with its default quotient width of 16, which gives a 32-bit dividend. At this width the extreme boundaries can be hit directly and exactly: quotients of 65535 and 65536, -32768 and +32768, and the most negative dividend divided by -1. Random operands draw the divisor from a small range part of the time, so overflow in both modes comes up often. A retrigger in the middle of an operation checks that a start while busy is ignored.

// File: rtl/wdu_pkg.sv
package wdu_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;
endpackage

// File: rtl/wdu_prep.sv
module wdu_prep #(
  parameter int Q_W = 16
) (
  input  logic [2*Q_W-1:0] dvd_i,
  input  logic [Q_W-1:0]   dvs_i,
  input  logic             sgn_i,
  output logic [2*Q_W-1:0] mag_dvd_o,
  output logic [Q_W-1:0]   mag_dvs_o,
  output logic             neg_q_o,
  output logic             neg_r_o,
  output logic             pre_ovf_o,
  output logic             zero_o
);
  localparam int D_W = 2 * Q_W;
  logic dvd_neg, dvs_neg;

  always_comb begin
    dvd_neg   = sgn_i & dvd_i[D_W-1];
    dvs_neg   = sgn_i & dvs_i[Q_W-1];
    mag_dvd_o = dvd_neg ? -dvd_i : dvd_i;
    mag_dvs_o = dvs_neg ? -dvs_i : dvs_i;
    neg_q_o   = dvd_neg ^ dvs_neg;
    neg_r_o   = dvd_neg;
    // magnitude quotient needs more than Q_W bits
    pre_ovf_o = mag_dvd_o[D_W-1:Q_W] >= mag_dvs_o;
    zero_o    = (dvs_i == '0);
  end
endmodule

// File: rtl/wdu_step.sv
module wdu_step #(
  parameter int Q_W = 16
) (
  input  logic [Q_W-1:0] rem_i,
  input  logic [Q_W-1:0] quo_i,
  input  logic [Q_W-1:0] dvs_i,
  output logic [Q_W-1:0] rem_o,
  output logic [Q_W-1:0] quo_o
);
  logic [Q_W:0] trial;
  logic         fits;

  always_comb begin
    trial = {rem_i, quo_i[Q_W-1]};
    fits  = trial >= {1'b0, dvs_i};
    // when fits, the true difference is below dvs_i and fits in Q_W bits
    rem_o = fits ? (trial[Q_W-1:0] - dvs_i) : trial[Q_W-1:0];
    quo_o = {quo_i[Q_W-2:0], fits};
  end
endmodule

// File: rtl/wdu_finish.sv
module wdu_finish #(
  parameter int Q_W = 16
) (
  input  logic [Q_W-1:0] quo_mag_i,
  input  logic [Q_W-1:0] rem_mag_i,
  input  logic           neg_q_i,
  input  logic           neg_r_i,
  input  logic           sgn_i,
  input  logic           pre_ovf_i,
  output logic [Q_W-1:0] quo_o,
  output logic [Q_W-1:0] rem_o,
  output logic           ovf_o
);
  localparam logic [Q_W-1:0] HALF = {1'b1, {(Q_W-1){1'b0}}};
  logic sgn_ovf;

  always_comb begin
    quo_o   = neg_q_i ? -quo_mag_i : quo_mag_i;
    rem_o   = neg_r_i ? -rem_mag_i : rem_mag_i;
    sgn_ovf = neg_q_i ? (quo_mag_i > HALF) : quo_mag_i[Q_W-1];
    ovf_o   = pre_ovf_i | (sgn_i & sgn_ovf);
  end
endmodule

// File: rtl/word_div_unit.sv
module word_div_unit #(
  parameter int Q_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             signed_i,
  input  logic [2*Q_W-1:0] dividend_i,
  input  logic [Q_W-1:0]   divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [2*Q_W-1:0] result_o,
  output logic             n_o,
  output logic             z_o,
  output logic             v_o,
  output logic             c_o,
  output logic             div_zero_o
);
  import wdu_pkg::*;

  localparam int D_W   = 2 * Q_W;
  localparam int CNT_W = $clog2(Q_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(Q_W - 1);

  logic             busy_q, done_q, dbz_q;
  logic [CNT_W-1:0] cnt_q;
  logic [Q_W-1:0]   rem_q, quo_q, dvs_q;
  logic [D_W-1:0]   dvd_q, res_q;
  logic             neg_q_q, neg_r_q, sgn_q, pre_ovf_q;
  ccr_t             ccr_q;

  logic [D_W-1:0] mag_dvd;
  logic [Q_W-1:0] mag_dvs;
  logic           p_neg_q, p_neg_r, p_pre_ovf, p_zero;
  logic [Q_W-1:0] s_rem, s_quo, f_quo, f_rem;
  logic           f_ovf, accept;

  wdu_prep #(.Q_W(Q_W)) u_prep (
    .dvd_i(dividend_i), .dvs_i(divisor_i), .sgn_i(signed_i),
    .mag_dvd_o(mag_dvd), .mag_dvs_o(mag_dvs), .neg_q_o(p_neg_q),
    .neg_r_o(p_neg_r), .pre_ovf_o(p_pre_ovf), .zero_o(p_zero)
  );

  wdu_step #(.Q_W(Q_W)) u_step (
    .rem_i(rem_q), .quo_i(quo_q), .dvs_i(dvs_q),
    .rem_o(s_rem), .quo_o(s_quo)
  );

  wdu_finish #(.Q_W(Q_W)) u_finish (
    .quo_mag_i(s_quo), .rem_mag_i(s_rem), .neg_q_i(neg_q_q),
    .neg_r_i(neg_r_q), .sgn_i(sgn_q), .pre_ovf_i(pre_ovf_q),
    .quo_o(f_quo), .rem_o(f_rem), .ovf_o(f_ovf)
  );

  assign accept = start_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      dbz_q     <= 1'b0;
      cnt_q     <= '0;
      rem_q     <= '0;
      quo_q     <= '0;
      dvs_q     <= '0;
      dvd_q     <= '0;
      res_q     <= '0;
      neg_q_q   <= 1'b0;
      neg_r_q   <= 1'b0;
      sgn_q     <= 1'b0;
      pre_ovf_q <= 1'b0;
      ccr_q     <= '0;
    end else begin
      done_q <= 1'b0;
      dbz_q  <= 1'b0;
      if (accept) begin
        if (p_zero) begin
          dbz_q <= 1'b1;
        end else begin
          busy_q    <= 1'b1;
          cnt_q     <= '0;
          rem_q     <= mag_dvd[D_W-1:Q_W];
          quo_q     <= mag_dvd[Q_W-1:0];
          dvs_q     <= mag_dvs;
          dvd_q     <= dividend_i;
          neg_q_q   <= p_neg_q;
          neg_r_q   <= p_neg_r;
          sgn_q     <= signed_i;
          pre_ovf_q <= p_pre_ovf;
        end
      end else if (busy_q) begin
        rem_q <= s_rem;
        quo_q <= s_quo;
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == LAST) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          ccr_q.c <= 1'b0;
          if (f_ovf) begin
            res_q   <= dvd_q;
            ccr_q.v <= 1'b1;
          end else begin
            res_q   <= {f_rem, f_quo};
            ccr_q.n <= f_quo[Q_W-1];
            ccr_q.z <= (f_quo == '0);
            ccr_q.v <= 1'b0;
          end
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign div_zero_o = dbz_q;
  assign result_o   = res_q;
  assign n_o        = ccr_q.n;
  assign z_o        = ccr_q.z;
  assign v_o        = ccr_q.v;
  assign c_o        = ccr_q.c;

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_done_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  p_done_after_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));
  p_rem_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !pre_ovf_q |-> rem_q < dvs_q);
  p_ovf_dividend_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && v_o |-> result_o == dvd_q);
  p_ovf_keeps_nz_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && v_o |-> (n_o == $past(n_o)) && (z_o == $past(z_o)));
  p_carry_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !c_o);
  p_zero_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !v_o |-> z_o == (result_o[Q_W-1:0] == '0));
  p_dbz_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_zero_o |-> !busy_o && !done_o && $stable(result_o));
  p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(dvd_q));
endmodule

// File: tb/word_div_unit_test.sv
`timescale 1ns/1ps
module word_div_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sgn = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy, done, dz, n, z, v, c;
  logic [31:0] result;

  int unsigned vectors = 0;
  int unsigned fails = 0;
  int unsigned cycles = 0;

  logic [31:0] exp_res = '0;
  logic        exp_n = 1'b0, exp_z = 1'b0, exp_v = 1'b0;

  always #5 clk = ~clk;

  word_div_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn),
    .dividend_i(dividend), .divisor_i(divisor), .busy_o(busy), .done_o(done),
    .result_o(result), .n_o(n), .z_o(z), .v_o(v), .c_o(c), .div_zero_o(dz)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog act=%0d exp=<150000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors = vectors + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] a, input logic [15:0] b, input logic s,
                                output logic ovf, output logic [31:0] res);
    longint q, r;
    if (s) begin
      q = longint'($signed(a)) / longint'($signed(b));
      r = longint'($signed(a)) % longint'($signed(b));
      ovf = (q > 32767) || (q < -32768);
    end else begin
      q = longint'(a) / longint'(b);
      r = longint'(a) % longint'(b);
      ovf = q > 65535;
    end
    res = ovf ? a : {r[15:0], q[15:0]};
  endfunction

  task automatic run_op(input logic [31:0] a, input logic [15:0] b, input logic s,
                        input logic poke, input string req);
    logic ovf;
    logic [31:0] res;
    @(negedge clk);
    dividend = a; divisor = b; sgn = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (b == 16'h0) begin
      chk("R6 dbz pulse", {31'b0, dz}, 32'd1);
      chk("R6 busy low", {31'b0, busy}, 32'd0);
      chk("R6 result held", result, exp_res);
      @(negedge clk);
      chk("R6 dbz single", {31'b0, dz}, 32'd0);
      chk("R6 no done", {31'b0, done}, 32'd0);
      chk("R6 flags held", {28'b0, n, z, v, c}, {28'b0, exp_n, exp_z, exp_v, 1'b0});
      return;
    end
    model(a, b, s, ovf, res);
    for (int i = 1; i <= 16; i++) begin
      if (i < 16) chk("R7 busy", {30'b0, busy, done}, 32'd2);
      if (poke && i == 4) begin
        dividend = ~a; divisor = b ^ 16'h0101; sgn = ~s; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
    end
    chk("R7 done", {30'b0, busy, done}, 32'd1);
    exp_res = res;
    exp_v = ovf;
    if (!ovf) begin
      exp_n = res[15];
      exp_z = (res[15:0] == 16'h0);
    end
    chk(poke ? "R8 result" : req, result, exp_res);
    chk("R5 flags", {28'b0, n, z, v, c}, {28'b0, exp_n, exp_z, exp_v, 1'b0});
    @(negedge clk);
    chk("R7 pulse", {31'b0, done}, 32'd0);
    chk("R7 hold", result, exp_res);
  endtask

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    chk("R9 reset out", {24'b0, busy, done, dz, n, z, v, c, 1'b0}, 32'd0);
    chk("R9 reset result", result, 32'd0);
    rst_n = 1'b1;
    // directed corners
    run_op(32'd100, 16'd7, 1'b0, 1'b0, "R1 basic");
    run_op(32'd5, 16'd9, 1'b0, 1'b0, "R5 zero quotient");
    run_op(32'hFFFE_0001, 16'hFFFF, 1'b0, 1'b0, "R1 max quotient");
    run_op(32'h0001_0000, 16'd1, 1'b0, 1'b0, "R3 quotient 65536");
    run_op(32'hFFFF_FFFF, 16'hFFFF, 1'b0, 1'b0, "R3 big");
    run_op(32'hFFFF_FFF9, 16'd2, 1'b1, 1'b0, "R2 -7/2");
    run_op(32'd7, 16'hFFFE, 1'b1, 1'b0, "R2 7/-2");
    run_op(32'hFFFF_8000, 16'd1, 1'b1, 1'b0, "R2 -32768/1");
    run_op(32'hFFFF_0000, 16'd2, 1'b1, 1'b0, "R2 -65536/2");
    run_op(32'h0001_0000, 16'hFFFE, 1'b1, 1'b0, "R2 65536/-2");
    run_op(32'h0000_8000, 16'd1, 1'b1, 1'b0, "R4 +32768");
    run_op(32'h8000_0000, 16'hFFFF, 1'b1, 1'b0, "R4 min/-1");
    run_op(32'h8000_0000, 16'h8000, 1'b1, 1'b0, "R4 min/min");
    run_op(32'd1234, 16'd0, 1'b0, 1'b0, "R6 unsigned zero");
    run_op(32'hFFFF_0000, 16'd0, 1'b1, 1'b0, "R6 signed zero");
    run_op(32'd99999, 16'd321, 1'b0, 1'b1, "R8 retrigger");
    run_op(32'hFFF0_1234, 16'hF00D, 1'b1, 1'b1, "R8 retrigger signed");
    // random mix
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a;
      logic [15:0] b;
      logic s;
      a = $urandom;
      if (k % 3 == 0) a = {{16{a[31]}}, a[15:0]};
      b = $urandom;
      if (k % 4 == 1) b = 16'($urandom % 8);
      s = 1'($urandom % 2);
      run_op(a, b, s, (k % 25) == 0, s ? "R2 random" : "R1 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule